// File: doc/BRIEF.md
# Burst command packet serializer

This block takes a read or write burst request from a memory-side bus and turns it into a packet of 65-bit network flits. A request carries a 40-bit byte address, a byte length, a read/write flag, a 14-bit source identifier and a 4-bit transaction identifier. The block checks the request against the burst rules. If the request is legal, it emits one header flit. A read packet is that header alone. A write packet is the header followed by 64-bit write data flits taken from a separate data stream. The most significant bit of every flit is the end-of-packet marker.

Requests that break the rules produce no flits. They are dropped, and a sticky error flag is raised. The rules are: the address must fall on a 32-bit word boundary, the length must be a non-zero multiple of four bytes, and the burst must stay inside one 64-byte line. While a packet is in flight, the request port is held off. The downstream side can stall at any flit, and the flit on offer then stays as it is.

Top module: `burst_cmd_serializer`

## Requirements
- R1: After reset, `flit_valid` and `err_flag` are 0 and `req_ready` is 1.
- R2: The header flit holds these fields: bit 64 end-of-packet, bits 63:26 address bits 39:2, bits 25:24 zero, bits 23:20 word count, bits 19:18 command, bits 17:4 source identifier, bits 3:0 transaction identifier.
- R3: The header word count field equals the byte length divided by 4, minus 1.
- R4: The header command field is 00 for a read and 01 for a write. Bit 19 of a header is never 1.
- R5: A legal read gives exactly one flit, the header, with bit 64 set. The header appears in the cycle after the request is accepted.
- R6: A legal write gives a header with bit 64 clear, then ceil(words/2) data flits. Each data flit carries the input data beat in bits 63:0. Only the last data flit has bit 64 set.
- R7: A request whose address bits 1:0 are not zero produces no flit and sets `err_flag`.
- R8: A request whose length is zero or not a multiple of 4 produces no flit and sets `err_flag`.
- R9: A request with (address mod 64) + length greater than 64 produces no flit and sets `err_flag`. A burst that ends exactly at the line end is legal.
- R10: While `flit_valid` is 1 and `flit_ready` is 0, the flit stays unchanged in the next cycle. During a data-phase stall, `wdata_ready` is 0.
- R11: `req_ready` stays 0 from acceptance of a legal request until the transfer of its end-of-packet flit. A request held pending meanwhile is accepted only afterwards.
- R12: Once set, `err_flag` stays 1 until reset, and later legal requests are still serialized normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_addr | input | 40 | Byte address of the burst |
| req_len | input | 7 | Burst length in bytes |
| req_write | input | 1 | 1 for write, 0 for read |
| req_srcid | input | 14 | Source identifier |
| req_trdid | input | 4 | Transaction identifier |
| wdata_valid | input | 1 | Write data beat offered |
| wdata_ready | output | 1 | Write data beat taken |
| wdata | input | 64 | Write data beat (two 32-bit words) |
| flit_valid | output | 1 | Flit offered |
| flit_ready | input | 1 | Downstream takes the flit |
| flit | output | 65 | Flit; bit 64 is end-of-packet |
| err_flag | output | 1 | Sticky flag for a dropped illegal request |

## Verification
A corrupted header register or a wrong legality decision shows at the ports in the cycle after acceptance. It appears as a wrong header, or as a flit where none should be, with `err_flag` not moving. A wrong count in the beat counter shows at the end of the data phase. There the end-of-packet bit comes one flit early or late, and `req_ready` returns at the wrong cycle. A state machine stuck busy shows as `req_ready` held low after the last flit, which the next vector exposes immediately.

// File: rtl/bcs_pkg.sv
// Shared definitions for the burst command serializer.
// Assumes a two-bit command field in the header flit.
package bcs_pkg;
    localparam int CMD_W = 2;
    localparam logic [CMD_W-1:0] CMD_RD = 2'b00;
    localparam logic [CMD_W-1:0] CMD_WR = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_DATA = 2'd2
    } bcs_state_e;
endpackage

// File: rtl/bcs_req_check.sv
// Combinational legality check and header packing for one request.
// Assumes LEN_W = log2(LINE_BYTES)+1 and a header exactly FLIT_W bits wide.
module bcs_req_check
    import bcs_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int LEN_W      = 7,
    parameter int SRC_W      = 14,
    parameter int TRD_W      = 4,
    parameter int LINE_BYTES = 64,
    parameter int WLEN_W     = 4,
    parameter int FLIT_W     = 65
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              is_write,
    input  logic [SRC_W-1:0]  srcid,
    input  logic [TRD_W-1:0]  trdid,
    output logic              legal,
    output logic [FLIT_W-1:0] header
);
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int HADDR_W = ADDR_W - 2;
    localparam int RES_W   = FLIT_W - 1 - HADDR_W - WLEN_W - CMD_W - SRC_W - TRD_W;

    logic [LEN_W:0]      line_end;
    logic                aligned;
    logic                len_ok;
    logic                fits;
    logic [WLEN_W-1:0]   wlen;
    logic [CMD_W-1:0]    cmd;

    // Rule checks: word alignment, length granularity, single-line burst.
    always_comb begin
        line_end = {{(LEN_W+1-OFF_W){1'b0}}, addr[OFF_W-1:0]} + {1'b0, len};
        aligned  = (addr[1:0] == 2'b00);
        len_ok   = (len != '0) && (len[1:0] == 2'b00);
        fits     = (line_end <= (LEN_W+1)'(LINE_BYTES));
        legal    = aligned && len_ok && fits;
    end

    // Header packing: word count minus one wraps to all-ones for a full line.
    always_comb begin
        wlen   = len[WLEN_W+1:2] - WLEN_W'(1);
        cmd    = is_write ? CMD_WR : CMD_RD;
        header = {~is_write, addr[ADDR_W-1:2], {RES_W{1'b0}}, wlen, cmd, srcid, trdid};
    end
endmodule

// File: rtl/bcs_word_counter.sv
// Counts 32-bit words left in the write data phase, two per data flit.
// Assumes load and dec never assert in the same cycle.
module bcs_word_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_words,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] remain;

    // Remaining-word register: loaded at header transfer, minus two per data flit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_words;
        else if (dec)
            remain <= (remain > CNT_W'(2)) ? remain - CNT_W'(2) : '0;
    end

    // Final flit when at most two words are left.
    always_comb last = (remain <= CNT_W'(2));
endmodule

// File: rtl/bcs_ctrl.sv
// Packet sequencing FSM: idle, header offer, data pass-through.
// Assumes upstream data holds stable while it waits for ready.
module bcs_ctrl
    import bcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_legal,
    input  logic hdr_eop,
    input  logic flit_ready,
    input  logic wdata_valid,
    input  logic data_last,
    output logic req_ready,
    output logic accept_ok,
    output logic flit_valid,
    output logic wdata_ready,
    output logic sel_data,
    output logic cnt_load,
    output logic cnt_dec,
    output logic err_flag
);
    bcs_state_e state, state_nx;
    logic accept, head_fire, data_fire;

    // Handshake decode for the current state.
    always_comb begin
        req_ready   = (state == ST_IDLE);
        accept      = req_valid && req_ready;
        accept_ok   = accept && req_legal;
        sel_data    = (state == ST_DATA);
        flit_valid  = (state == ST_HEAD) || (sel_data && wdata_valid);
        wdata_ready = sel_data && flit_ready;
        head_fire   = (state == ST_HEAD) && flit_ready;
        data_fire   = sel_data && wdata_valid && flit_ready;
        cnt_load    = head_fire && !hdr_eop;
        cnt_dec     = data_fire;
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (accept_ok) state_nx = ST_HEAD;
            ST_HEAD: if (head_fire) state_nx = hdr_eop ? ST_IDLE : ST_DATA;
            ST_DATA: if (data_fire && data_last) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Sticky error on an accepted illegal request.
    always_ff @(posedge clk) begin
        if (!rst_n)                    err_flag <= 1'b0;
        else if (accept && !req_legal) err_flag <= 1'b1;
    end
endmodule

// File: rtl/burst_cmd_serializer.sv
// Top level: checks a burst request, registers its header flit, then
// passes write data beats through as payload flits with end-of-packet.
// Assumes FLIT_W = DATA_W + 1 and a 64-byte line at default settings.
module burst_cmd_serializer #(
    parameter int ADDR_W     = 40,
    parameter int SRC_W      = 14,
    parameter int TRD_W      = 4,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 64,
    localparam int LEN_W     = $clog2(LINE_BYTES) + 1,
    localparam int FLIT_W    = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    input  logic [SRC_W-1:0]  req_srcid,
    input  logic [TRD_W-1:0]  req_trdid,
    input  logic              wdata_valid,
    output logic              wdata_ready,
    input  logic [DATA_W-1:0] wdata,
    output logic              flit_valid,
    input  logic              flit_ready,
    output logic [FLIT_W-1:0] flit,
    output logic              err_flag
);
    localparam int WLEN_W  = $clog2(LINE_BYTES / 4);
    localparam int CNT_W   = LEN_W - 2;
    localparam int WLEN_LO = TRD_W + SRC_W + bcs_pkg::CMD_W;

    logic              legal, accept_ok, sel_data, cnt_load, cnt_dec, data_last;
    logic [FLIT_W-1:0] hdr_new, hdr_q;
    logic [CNT_W-1:0]  hdr_words;

    bcs_req_check #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SRC_W(SRC_W), .TRD_W(TRD_W),
        .LINE_BYTES(LINE_BYTES), .WLEN_W(WLEN_W), .FLIT_W(FLIT_W)
    ) u_check (
        .addr(req_addr), .len(req_len), .is_write(req_write),
        .srcid(req_srcid), .trdid(req_trdid),
        .legal(legal), .header(hdr_new)
    );

    bcs_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_legal(legal),
        .hdr_eop(hdr_q[FLIT_W-1]), .flit_ready(flit_ready),
        .wdata_valid(wdata_valid), .data_last(data_last),
        .req_ready(req_ready), .accept_ok(accept_ok), .flit_valid(flit_valid),
        .wdata_ready(wdata_ready), .sel_data(sel_data),
        .cnt_load(cnt_load), .cnt_dec(cnt_dec), .err_flag(err_flag)
    );

    // Word count recovered from the stored header field (field + 1).
    always_comb hdr_words = {1'b0, hdr_q[WLEN_LO +: WLEN_W]} + CNT_W'(1);

    bcs_word_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_words(hdr_words),
        .dec(cnt_dec), .last(data_last)
    );

    // Header register, captured when a legal request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)         hdr_q <= '0;
        else if (accept_ok) hdr_q <= hdr_new;
    end

    // Output mux: stored header, or data beat tagged with end-of-packet.
    always_comb flit = sel_data ? {data_last, wdata} : hdr_q;
endmodule

// File: rtl/bcs_checker.sv
// Protocol checker for the serializer, bound to every instance of the top.
// Assumes default header field positions derived from the widths below.
module bcs_checker #(
    parameter int FLIT_W = 65,
    parameter int SRC_W  = 14,
    parameter int TRD_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        addr_lo,
    input logic              flit_valid,
    input logic              flit_ready,
    input logic [FLIT_W-1:0] flit,
    input logic              err_flag
);
    localparam int CMD_LO = TRD_W + SRC_W;
    localparam int CMD_HI = CMD_LO + 1;
    localparam int RES_LO = CMD_LO + 2 + 4;

    logic in_pkt;
    logic head_now;

    // Tracks whether a packet has started but its last flit is not yet gone.
    always_ff @(posedge clk) begin
        if (!rst_n)                        in_pkt <= 1'b0;
        else if (flit_valid && flit_ready) in_pkt <= !flit[FLIT_W-1];
    end

    always_comb head_now = flit_valid && !in_pkt;

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && !flit_ready) |=> (flit_valid && $stable(flit)));

    p_cmd_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        head_now |-> (!flit[CMD_HI] && flit[RES_LO +: 2] == 2'b00));

    p_read_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (head_now && !flit[CMD_LO]) |-> flit[FLIT_W-1]);

    p_busy_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pkt || flit_valid) |-> !req_ready);

    p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_misalign_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && addr_lo != 2'b00) |=> (err_flag && !flit_valid));
endmodule

bind burst_cmd_serializer bcs_checker #(
    .FLIT_W(FLIT_W), .SRC_W(SRC_W), .TRD_W(TRD_W)
) u_bcs_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .addr_lo(req_addr[1:0]), .flit_valid(flit_valid), .flit_ready(flit_ready),
    .flit(flit), .err_flag(err_flag)
);

// File: tb/sim_burst_cmd_serializer.sv
`timescale 1ns/1ps
module sim_burst_cmd_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [39:0] req_addr = '0;
    logic [6:0]  req_len = '0;
    logic [13:0] req_srcid = '0;
    logic [3:0]  req_trdid = '0;
    logic        wdata_valid = 1'b0, wdata_ready;
    logic [63:0] wdata = '0;
    logic        flit_valid, flit_ready = 1'b1, err_flag;
    logic [64:0] flit;

    int total = 0, bad = 0;
    bit done = 0;

    burst_cmd_serializer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
        .req_srcid(req_srcid), .req_trdid(req_trdid),
        .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
        .flit_valid(flit_valid), .flit_ready(flit_ready), .flit(flit),
        .err_flag(err_flag)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic [39:0] addr;
        logic [6:0]  len;
        logic        wr;
        logic [13:0] src;
        logic [3:0]  trd;
        logic        ok;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{40'h12_3456_7800, 7'd4,  1'b0, 14'h0001, 4'h1, 1'b1, 8'd5},  // R5 one-word read
        '{40'h00_0000_0040, 7'd64, 1'b1, 14'h3FFF, 4'hF, 1'b1, 8'd6},  // R6 full line write
        '{40'h00_0000_0104, 7'd12, 1'b1, 14'h02A5, 4'h3, 1'b1, 8'd6},  // R6 odd word count
        '{40'hFF_FFFF_FFF0, 7'd16, 1'b1, 14'h1234, 4'h7, 1'b1, 8'd9},  // R9 ends at line end
        '{40'h00_0000_0038, 7'd8,  1'b0, 14'h2000, 4'h8, 1'b1, 8'd3},  // R3 read of two words
        '{40'h00_0000_0102, 7'd4,  1'b0, 14'h0011, 4'h2, 1'b0, 8'd7},  // R7 misaligned
        '{40'h00_0000_0200, 7'd0,  1'b1, 14'h0012, 4'h2, 1'b0, 8'd8},  // R8 zero length
        '{40'h00_0000_0200, 7'd6,  1'b0, 14'h0013, 4'h2, 1'b0, 8'd8},  // R8 not multiple of 4
        '{40'h00_0000_003C, 7'd8,  1'b0, 14'h0014, 4'h2, 1'b0, 8'd9},  // R9 crosses line
        '{40'h00_0000_0000, 7'd68, 1'b1, 14'h0015, 4'h2, 1'b0, 8'd9},  // R9 longer than line
        '{40'h00_0000_0080, 7'd8,  1'b1, 14'h0A0A, 4'hA, 1'b1, 8'd12}  // R12 works after error
    };

    function automatic logic [64:0] exp_hdr(logic [39:0] a, logic [6:0] l, logic w,
                                            logic [13:0] s, logic [3:0] t);
        logic [6:0] wl;
        wl = (l >> 2) - 7'd1;
        return {~w, a[39:2], 2'b00, wl[3:0], 1'b0, w, s, t};
    endfunction

    function automatic logic [63:0] pat(int v, int b);
        return {16'hDA7A, 16'(v), 16'h0B0B, 16'(b)};
    endfunction

    task automatic check(string tag, logic [64:0] act, logic [64:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_req(vec_t v);
        req_addr = v.addr; req_len = v.len; req_write = v.wr;
        req_srcid = v.src; req_trdid = v.trd; req_valid = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit   exp_err;
        int   nf;
        vec_t sv;
        logic [64:0] held;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 flit_valid", 65'(flit_valid), 65'd0);
        check("R1 req_ready", 65'(req_ready), 65'd1);
        check("R1 err_flag", 65'(err_flag), 65'd0);

        exp_err = 0;
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            @(negedge clk); drive_req(v);
            @(posedge clk);
            @(negedge clk); req_valid = 1'b0;
            #1;
            if (v.ok) begin
                check($sformatf("R2 R3 R4 header vec%0d tag R%0d", i, v.tag), flit,
                      exp_hdr(v.addr, v.len, v.wr, v.src, v.trd));
                check($sformatf("R5 R6 header valid vec%0d", i), 65'(flit_valid), 65'd1);
                @(posedge clk);
                if (v.wr) begin
                    nf = (int'(v.len) / 4 + 1) / 2;
                    for (int b = 0; b < nf; b++) begin
                        @(negedge clk);
                        wdata_valid = 1'b1; wdata = pat(i, b);
                        #1;
                        check($sformatf("R6 data vec%0d beat%0d", i, b), flit,
                              {(b == nf - 1), pat(i, b)});
                        @(posedge clk);
                    end
                end
                @(negedge clk); wdata_valid = 1'b0;
                #1;
                check($sformatf("R5 R6 packet end vec%0d", i),
                      {63'd0, flit_valid, req_ready}, 65'b01);
            end else begin
                exp_err = 1;
                check($sformatf("R%0d drop vec%0d", v.tag, i), 65'(flit_valid), 65'd0);
                check($sformatf("R%0d error vec%0d", v.tag, i), 65'(err_flag), 65'd1);
            end
            check($sformatf("R12 sticky vec%0d", i), 65'(err_flag), 65'(exp_err));
        end

        // R10 and R11: stalled write while a second request waits.
        flit_ready = 1'b0;
        sv = '{40'h00_0000_0200, 7'd8, 1'b1, 14'h0777, 4'h5, 1'b1, 8'd10};
        @(negedge clk); drive_req(sv);
        @(posedge clk);
        @(negedge clk);
        drive_req('{40'h00_0000_0300, 7'd4, 1'b0, 14'h0555, 4'h6, 1'b1, 8'd11});
        #1;
        held = flit;
        check("R10 stalled header", held, exp_hdr(sv.addr, sv.len, sv.wr, sv.src, sv.trd));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            check("R10 header held", flit, held);
            check("R11 busy during stall", 65'(req_ready), 65'd0);
        end
        flit_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flit_ready = 1'b0; wdata_valid = 1'b1; wdata = pat(99, 0);
        #1;
        check("R10 wdata_ready in stall", 65'(wdata_ready), 65'd0);
        check("R11 busy in data phase", 65'(req_ready), 65'd0);
        @(negedge clk); #1;
        check("R10 data flit held", flit, {1'b1, pat(99, 0)});
        flit_ready = 1'b1;
        @(posedge clk);
        @(negedge clk); wdata_valid = 1'b0;
        #1;
        check("R11 ready after eop", 65'(req_ready), 65'd1);
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0;
        #1;
        check("R11 pending read served", flit,
              exp_hdr(40'h00_0000_0300, 7'd4, 1'b0, 14'h0555, 4'h6));
        @(posedge clk);
        @(negedge clk); #1;
        check("R5 pending read single flit", 65'(flit_valid), 65'd0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule